// File: doc/BRIEF.md
# Multichannel Serial Converter Readout Controller

This controller sits on the host side of a multichannel current-input converter and collects one frame of conversion results per conversion. It waits for the converter's active-low data-ready strobe to fall, then drives a data clock that idles low. It samples the serial data line on each rising edge of that clock. The first bit is already on the line when the strobe falls. The converter moves to the next bit on each falling edge, and its first falling edge releases the strobe. Channel words arrive highest channel first, each one most significant bit first. Each word is either 20 bits or the same word shortened to its upper 16 bits.

Each received word is in offset binary with a small zero point, not mid-scale. The controller subtracts that zero code and presents a two's-complement result on a valid/ready stream, one word per handshake, with a channel index. A one-cycle completion pulse follows the last channel. The conversion-toggle input is watched. The data clock stays quiet for a guard interval after every toggle transition, and also ahead of the next predicted transition. To predict it, the controller measures the spacing of the last two transitions. A readout that meets a guard window pauses at a bit boundary and then resumes.

Stream rules: `out_valid` is raised with `out_chan`/`out_data` and holds all three unchanged until a cycle with `out_ready` high. The transfer takes place on that clock edge. If the consumer stalls, the data clock stops just before the last bit of the following word, so no word is ever dropped. The data-ready strobe, conversion toggle and format inputs are plain inputs and are taken to be synchronous to `clk`.

Top module: `adc_readout_ctrl`

## Requirements
- R1: With no falling edge on `dv_n` while idle, `sclk` stays low and makes no rising edge. A readout begins only from such an edge.
- R2: Each data-clock bit lasts at least DIV system cycles, with `sclk` high for exactly DIV/2 cycles. `sdi` is sampled on the rising edge, and the first bit is taken before any falling edge.
- R3: The output words of a readout carry `out_chan` values N_CH-1, N_CH-2, ... 0 in that order, and each word is assembled MSB first.
- R4: `fmt_wide` is sampled when the readout starts. When it is 1, words are 20 bits and `out_data` = word - 0x01000. When it is 0, words are 16 bits and `out_data` = word - 0x0100. Both results are OUT_W-bit two's complement.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_chan` and `out_data` hold their values. During such a stall `sclk` makes fewer than WIDE rising edges.
- R6: `done` is high for one cycle, in the cycle after the handshake of channel 0. It happens once per readout.
- R7: A falling edge on `dv_n` during a readout sets `overrun`. The running readout completes with correct data, no new readout starts from that edge, and `overrun` clears when the next readout starts.
- R8: No `sclk` transition occurs within GUARD cycles after a `conv_tgl` transition.
- R9: Once two `conv_tgl` transitions have fixed the interval, and while that interval stays constant, no `sclk` transition occurs within GUARD cycles before a `conv_tgl` transition. Bits are paused at boundaries and none is lost or repeated.
- R10: After reset, `sclk`, `out_valid`, `done` and `overrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_wide | input | 1 | 1 selects 20-bit words, 0 selects 16-bit words |
| dv_n | input | 1 | Converter data-ready strobe, active low |
| sdi | input | 1 | Serial data from the converter |
| conv_tgl | input | 1 | Conversion-toggle signal, monitored only |
| sclk | output | 1 | Data clock to the converter, idles low |
| out_valid | output | 1 | Result word valid |
| out_ready | input | 1 | Consumer accepts the result word |
| out_chan | output | CH_W | Channel index, N_CH-1 down to 0 |
| out_data | output | OUT_W | Signed result, zero input reads 0 |
| done | output | 1 | One-cycle pulse after the last channel |
| overrun | output | 1 | Strobe fell again during a readout |

## Verification
The bench builds the block with N_CH=4, DIV=4 and GUARD=8, so one frame is 80 data-clock bits at most. That lets ten complete readouts run in both word formats, each with the toggle guard cutting into it several times. The data codes cover the zero point, its neighbours on each side, the all-zeros and all-ones extremes, and codes that differ only in the four bits the 16-bit format drops. Ready patterns give an irregular stream, a 150-cycle stall and an injected strobe overrun.

// File: rtl/adc_rdo_pkg.sv
package adc_rdo_pkg;
  typedef enum logic [0:0] {
    RD_IDLE = 1'b0,
    RD_RUN  = 1'b1
  } rd_state_e;

  // Bit position of the offset-binary zero point inside a word of width w
  function automatic int zero_pos(input int w);
    return w - 8;
  endfunction
endpackage

// File: rtl/rdo_guard.sv
module rdo_guard #(
  parameter int GUARD = 16,
  parameter int DIV   = 4,
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl,
  input  logic bit_go,
  output logic quiet
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int               SUM_W   = CNT_W + 2;

  logic             tgl_q;
  logic             seen;
  logic             ivl_ok;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ivl;
  logic             tgl_edge;
  logic             post_block;
  logic             pre_block;
  logic [SUM_W-1:0] reach;

  assign tgl_edge   = tgl ^ tgl_q;
  assign post_block = (cnt < CNT_W'(GUARD));
  assign reach      = {2'b00, cnt} + SUM_W'(GUARD + DIV);
  assign pre_block  = ivl_ok && (reach >= {2'b00, ivl});
  assign quiet      = !tgl_edge && !post_block && !pre_block;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgl_q  <= 1'b0;
      seen   <= 1'b0;
      ivl_ok <= 1'b0;
      cnt    <= CNT_MAX;
      ivl    <= '0;
    end else if (tgl_edge) begin
      tgl_q  <= tgl;
      seen   <= 1'b1;
      ivl_ok <= seen && (cnt != CNT_MAX);
      ivl    <= cnt + 1'b1;
      cnt    <= '0;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R8: a bit never starts inside the window that follows a toggle edge
  a_r8_post_window: assert property (@(posedge clk) disable iff (!rst_n)
    bit_go |-> (!tgl_edge && cnt >= CNT_W'(GUARD)))
    else $error("bit started inside post-toggle guard");

  // R9: a bit never starts when it could run into the predicted next edge
  a_r9_pre_window: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_go && ivl_ok) |-> (reach < {2'b00, ivl}))
    else $error("bit started inside pre-toggle guard");
endmodule

// File: rtl/rdo_bitclk.sv
module rdo_bitclk #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic go,
  output logic busy,
  output logic sclk
);
  localparam int PH_W = $clog2(DIV);
  localparam int HALF = DIV / 2;

  logic [PH_W-1:0] ph;

  assign go = req && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sclk <= 1'b0;
      ph   <= '0;
    end else if (go) begin
      busy <= 1'b1;
      sclk <= 1'b1;
      ph   <= PH_W'(1);
    end else if (busy) begin
      if (ph == PH_W'(HALF)) sclk <= 1'b0;
      if (ph == PH_W'(DIV - 1)) begin
        busy <= 1'b0;
        ph   <= '0;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  // R2: the clock stays high at least two cycles once it rises
  a_r2_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |=> sclk)
    else $error("data clock high phase too short");

  // R1: outside a bit slot the data clock is low
  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk)
    else $error("data clock high while no bit is in flight");
endmodule

// File: rtl/rdo_decode.sv
module rdo_decode
  import adc_rdo_pkg::*;
#(
  parameter int WIDE   = 20,
  parameter int NARROW = 16,
  parameter int CH_W   = 5,
  parameter int OUT_W  = WIDE + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [WIDE-1:0]  ld_word,
  input  logic             ld_fmt,
  input  logic [CH_W-1:0]  ld_chan,
  output logic             can_ld,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CH_W-1:0]  out_chan,
  output logic [OUT_W-1:0] out_data
);
  localparam int ZP_WIDE   = zero_pos(WIDE);
  localparam int ZP_NARROW = zero_pos(NARROW);
  localparam logic [OUT_W-1:0] ZERO_WIDE   = OUT_W'(1) << ZP_WIDE;
  localparam logic [OUT_W-1:0] ZERO_NARROW = OUT_W'(1) << ZP_NARROW;

  logic [OUT_W-1:0] ext;
  logic [OUT_W-1:0] res;

  always_comb begin
    if (ld_fmt) ext = OUT_W'(ld_word);
    else        ext = OUT_W'(ld_word[NARROW-1:0]);
    res = ext - (ld_fmt ? ZERO_WIDE : ZERO_NARROW);
  end

  assign can_ld = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
    end else if (ld) begin
      out_valid <= 1'b1;
      out_chan  <= ld_chan;
      out_data  <= res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R5: a stalled word stays put
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_chan) && $stable(out_data)))
    else $error("stalled output changed");

  // R5: no load may overwrite a word the consumer has not taken
  a_r5_no_clobber: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> (!out_valid || out_ready))
    else $error("word loaded over a pending one");
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adc_rdo_pkg::*;
#(
  parameter int N_CH   = 32,
  parameter int WIDE   = 20,
  parameter int NARROW = 16,
  parameter int DIV    = 4,
  parameter int GUARD  = 16,
  parameter int CNT_W  = 16,
  localparam int CH_W  = $clog2(N_CH),
  localparam int OUT_W = WIDE + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fmt_wide,
  input  logic             dv_n,
  input  logic             sdi,
  input  logic             conv_tgl,
  output logic             sclk,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CH_W-1:0]  out_chan,
  output logic [OUT_W-1:0] out_data,
  output logic             done,
  output logic             overrun
);
  localparam int BIT_W = $clog2(WIDE);
  localparam logic [BIT_W-1:0] LAST_WIDE   = BIT_W'(WIDE - 1);
  localparam logic [BIT_W-1:0] LAST_NARROW = BIT_W'(NARROW - 1);
  localparam logic [CH_W-1:0]  TOP_CH      = CH_W'(N_CH - 1);

  rd_state_e        state;
  logic             dv_q;
  logic             dv_fall;
  logic             fmt_q;
  logic [BIT_W-1:0] bit_idx;
  logic [CH_W-1:0]  ch_idx;
  logic [WIDE-2:0]  shreg;
  logic             all_loaded;
  logic             last_bit;
  logic             quiet;
  logic             can_ld;
  logic             req;
  logic             go;
  logic             busy;
  logic             ld;
  logic             last_take;

  assign dv_fall   = dv_q && !dv_n;
  assign last_bit  = (bit_idx == (fmt_q ? LAST_WIDE : LAST_NARROW));
  assign req       = (state == RD_RUN) && !all_loaded && quiet && (!last_bit || can_ld);
  assign ld        = go && last_bit;
  assign last_take = (state == RD_RUN) && all_loaded && out_valid && out_ready
                     && (out_chan == '0);

  rdo_guard #(.GUARD(GUARD), .DIV(DIV), .CNT_W(CNT_W)) u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .tgl    (conv_tgl),
    .bit_go (go),
    .quiet  (quiet)
  );

  rdo_bitclk #(.DIV(DIV)) u_bitclk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .go    (go),
    .busy  (busy),
    .sclk  (sclk)
  );

  rdo_decode #(.WIDE(WIDE), .NARROW(NARROW), .CH_W(CH_W), .OUT_W(OUT_W)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld        (ld),
    .ld_word   ({shreg, sdi}),
    .ld_fmt    (fmt_q),
    .ld_chan   (ch_idx),
    .can_ld    (can_ld),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_chan  (out_chan),
    .out_data  (out_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) dv_q <= 1'b1;
    else        dv_q <= dv_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= RD_IDLE;
      fmt_q      <= 1'b1;
      bit_idx    <= '0;
      ch_idx     <= TOP_CH;
      shreg      <= '0;
      all_loaded <= 1'b0;
      done       <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        RD_IDLE: begin
          if (dv_fall) begin
            state      <= RD_RUN;
            fmt_q      <= fmt_wide;
            bit_idx    <= '0;
            ch_idx     <= TOP_CH;
            all_loaded <= 1'b0;
            overrun    <= 1'b0;
          end
        end
        RD_RUN: begin
          if (dv_fall) overrun <= 1'b1;
          if (go) begin
            shreg <= {shreg[WIDE-3:0], sdi};
            if (last_bit) begin
              bit_idx <= '0;
              if (ch_idx == '0) all_loaded <= 1'b1;
              else              ch_idx     <= ch_idx - 1'b1;
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end
          if (last_take) begin
            done  <= 1'b1;
            state <= RD_IDLE;
          end
        end
        default: state <= RD_IDLE;
      endcase
    end
  end

  // R1: no bit is clocked while idle
  a_r1_no_idle_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RD_IDLE) |-> !go)
    else $error("bit clocked while idle");

  // R3: the first word of a readout belongs to the top channel
  a_r3_first_chan: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(state == RD_RUN)) |-> (ch_idx == TOP_CH))
    else $error("readout did not start at the top channel");

  // R6: done follows the handshake of channel 0 and lasts one cycle
  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready && out_chan == '0))
    else $error("done without final handshake");

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle");

  // R7: a strobe edge during a readout flags an overrun
  a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RD_RUN && dv_q && !dv_n) |=> overrun)
    else $error("overrun not flagged");
endmodule

// File: tb/sim_adc_readout_ctrl.sv
`timescale 1ns/1ps
module sim_adc_readout_ctrl;
  localparam int N_CH    = 4;
  localparam int WIDE    = 20;
  localparam int NARROW  = 16;
  localparam int DIV     = 4;
  localparam int GUARD   = 8;
  localparam int CNT_W   = 12;
  localparam int CH_W    = 2;
  localparam int OUT_W   = 21;
  localparam int TGL_PER = 60;
  localparam int N_RD    = 10;
  localparam int STALL_RD   = 4;
  localparam int OVERRUN_RD = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fmt_wide = 1'b1;
  logic dv_n;
  logic sdi;
  logic conv_tgl = 1'b0;
  logic sclk;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [CH_W-1:0] out_chan;
  logic [OUT_W-1:0] out_data;
  logic done;
  logic overrun;

  always #5 clk = ~clk;

  adc_readout_ctrl #(.N_CH(N_CH), .WIDE(WIDE), .NARROW(NARROW), .DIV(DIV),
                     .GUARD(GUARD), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .fmt_wide(fmt_wide), .dv_n(dv_n), .sdi(sdi),
    .conv_tgl(conv_tgl), .sclk(sclk), .out_valid(out_valid), .out_ready(out_ready),
    .out_chan(out_chan), .out_data(out_data), .done(done), .overrun(overrun)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [19:0] code_fn(input int rd, input int c);
    case ((rd * N_CH + c) % 8)
      0: return 20'h00000;
      1: return 20'h01000;
      2: return 20'hFFFFF;
      3: return 20'h00FFF;
      4: return 20'h01001;
      5: return 20'h0100F;
      6: return 20'h01010;
      default: return 20'((rd * 12345 + c * 7771 + 977) & 32'hFFFFF);
    endcase
  endfunction

  function automatic bit fmt_fn(input int rd);
    return (rd % 3) != 1;
  endfunction

  function automatic logic [OUT_W-1:0] exp_fn(input int rd, input int c);
    logic [19:0] code;
    code = code_fn(rd, c);
    if (fmt_fn(rd)) return OUT_W'(code) - OUT_W'(20'h01000);
    else            return OUT_W'(code[19:4]) - OUT_W'(16'h0100);
  endfunction

  // ---------------- converter model ----------------
  int conv_id = 0;
  int ack_id = 0;
  int bit_pos = 0;
  logic [19:0] codes [N_CH];
  logic cur_fmt = 1'b1;
  logic glitch = 1'b0;
  int s_wl, s_pos, s_word, s_bit;
  logic [19:0] s_code;
  int sclk_falls = 0;

  assign dv_n = (conv_id == ack_id) && !glitch;

  always @(negedge sclk) begin
    if (rst_n) begin
      sclk_falls++;
      if (ack_id != conv_id) begin
        ack_id = conv_id;
        bit_pos = 1;
      end else begin
        bit_pos = bit_pos + 1;
      end
    end
  end

  always_comb begin
    s_wl   = cur_fmt ? WIDE : NARROW;
    s_pos  = (ack_id == conv_id) ? bit_pos : 0;
    s_word = s_pos / s_wl;
    s_bit  = s_pos % s_wl;
    sdi    = 1'b0;
    s_code = '0;
    if (s_word < N_CH) begin
      s_code = codes[N_CH - 1 - s_word];
      if (!cur_fmt) s_code = {4'b0000, s_code[19:4]};
      sdi = s_code[s_wl - 1 - s_bit];
    end
  end

  // ---------------- toggle generator and guard monitor ----------------
  initial begin
    @(posedge rst_n);
    forever begin
      repeat (TGL_PER) @(negedge clk);
      conv_tgl = ~conv_tgl;
    end
  end

  time last_tgl_t = 0;
  time last_sclk_t = 0;
  int tgl_seen = 0;

  always @(conv_tgl) begin
    if ($time > 0) begin
      if (tgl_seen >= 2)
        chk(($time - last_sclk_t) >= GUARD * 10, "R9 pre-toggle quiet",
            longint'($time - last_sclk_t), longint'(GUARD * 10));
      last_tgl_t = $time;
      tgl_seen++;
    end
  end

  always @(sclk) begin
    if ($time > 0 && rst_n) begin
      if (tgl_seen >= 1)
        chk(($time - last_tgl_t) >= GUARD * 10, "R8 post-toggle quiet",
            longint'($time - last_tgl_t), longint'(GUARD * 10));
      last_sclk_t = $time;
    end
  end

  // ---------------- output monitor ----------------
  int cur_rd = -1;
  int mon_rd = 0;
  int ch_cnt = 0;
  int rd_done = 0;
  int cyc = 0;
  int hi_cnt = 0;
  int rises = 0;
  int since_rise = 0;
  bit seen_rise = 1'b0;
  logic sclk_prev = 1'b0;
  bit prev_stall = 1'b0;
  logic [CH_W-1:0] st_chan;
  logic [OUT_W-1:0] st_data;
  int stall_cnt = 0;
  int stall_rises0 = 0;
  bit stall_over = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      since_rise++;
      // data clock shape
      if (sclk && !sclk_prev) begin
        rises++;
        if (seen_rise)
          chk(since_rise >= DIV, "R2 bit period", since_rise, DIV);
        seen_rise = 1'b1;
        since_rise = 0;
      end
      if (sclk) hi_cnt++;
      else if (hi_cnt != 0) begin
        chk(hi_cnt == DIV / 2, "R2 high phase", hi_cnt, DIV / 2);
        hi_cnt = 0;
      end
      sclk_prev = sclk;

      // completion pulse from the previous edge
      if (done) begin
        chk(ch_cnt == N_CH, "R6 done after last channel", ch_cnt, N_CH);
        ch_cnt = 0;
        mon_rd++;
        rd_done++;
      end

      // stalled word must not have moved
      if (prev_stall) begin
        chk(out_valid == 1'b1, "R5 valid held", out_valid, 1);
        chk(out_chan == st_chan && out_data == st_data, "R5 word held",
            out_data, st_data);
      end

      // choose ready for the coming edge
      if (cur_rd == STALL_RD && !stall_over) begin
        out_ready = 1'b0;
        if (out_valid) begin
          if (stall_cnt == 0) stall_rises0 = rises;
          stall_cnt++;
          if (stall_cnt >= 150) begin
            chk((rises - stall_rises0) < WIDE, "R5 clock paused during stall",
                rises - stall_rises0, WIDE - 1);
            stall_over = 1'b1;
            out_ready = 1'b1;
          end
        end
      end else if (cur_rd % 2 == 1) begin
        out_ready = (cyc % 5) != 0 && (cyc % 7) != 3;
      end else begin
        out_ready = 1'b1;
      end

      // handshake at the coming edge
      if (out_valid && out_ready) begin
        chk(int'(out_chan) == N_CH - 1 - ch_cnt, "R3 channel order",
            out_chan, N_CH - 1 - ch_cnt);
        chk(out_data == exp_fn(mon_rd, N_CH - 1 - ch_cnt), "R4 result value",
            out_data, exp_fn(mon_rd, N_CH - 1 - ch_cnt));
        ch_cnt++;
      end
      prev_stall = out_valid && !out_ready;
      st_chan = out_chan;
      st_data = out_data;
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_readout(input int rd);
    int f0;
    @(negedge clk);
    cur_rd = rd;
    fmt_wide = fmt_fn(rd);
    cur_fmt = fmt_fn(rd);
    for (int c = 0; c < N_CH; c++) codes[c] = code_fn(rd, c);
    conv_id++;
    if (rd == OVERRUN_RD) begin
      f0 = sclk_falls;
      wait (sclk_falls >= f0 + 10);
      @(negedge clk);
      glitch = 1'b1;
      repeat (2) @(negedge clk);
      glitch = 1'b0;
    end
    if (rd == OVERRUN_RD + 1) begin
      repeat (3) @(negedge clk);
      chk(overrun == 1'b0, "R7 overrun cleared on new readout", overrun, 0);
    end
    wait (rd_done == rd + 1);
    @(negedge clk);
  endtask

  initial begin
    int r0;
    repeat (10) @(negedge clk);
    chk(sclk == 1'b0, "R10 reset sclk", sclk, 0);
    chk(out_valid == 1'b0, "R10 reset valid", out_valid, 0);
    chk(done == 1'b0, "R10 reset done", done, 0);
    chk(overrun == 1'b0, "R10 reset overrun", overrun, 0);
    rst_n = 1'b1;
    repeat (200) @(negedge clk);
    chk(rises == 0, "R1 no clock without strobe", rises, 0);
    chk(sclk == 1'b0, "R1 clock idles low", sclk, 0);
    for (int rd = 0; rd < N_RD; rd++) begin
      run_readout(rd);
      if (rd == OVERRUN_RD) begin
        chk(overrun == 1'b1, "R7 overrun flagged", overrun, 1);
        r0 = rises;
        repeat (120) @(negedge clk);
        chk(rises == r0, "R7 no readout from overrun edge", rises - r0, 0);
        chk(rd_done == rd + 1, "R7 no extra readout", rd_done, rd + 1);
      end else if (rd < OVERRUN_RD) begin
        chk(overrun == 1'b0, "R7 no overrun in clean readout", overrun, 0);
      end
    end
    r0 = rises;
    repeat (100) @(negedge clk);
    chk(rises == r0, "R1 quiet after final readout", rises - r0, 0);
    chk(rd_done == N_RD, "R6 one done per readout", rd_done, N_RD);
    chk(tgl_seen >= 3, "R9 guard exercised", tgl_seen, 3);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired rd_done=%0d expected=%0d", rd_done, N_RD);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule